// File: doc/BRIEF.md
# Local Bus Target Cycle Claimer

This block sits on the target side of a 486-style processor local bus. It watches every cycle the host opens with the address strobe and decodes the latched address against a fixed window. When the address falls inside the window, the block takes the cycle away from the chipset by pulling an active-low claim line. It then finishes the cycle itself. On a read it drives the shared data bus from a small internal register file. On a write it stores the bus data into that file under byte-enable control. Either way, it ends the cycle with a one-clock, active-low ready strobe.

A programmable wait count of 0 to 7 clocks stretches the cycle before ready. The chipset has only one claim input. The block therefore folds its own claim together with the claim lines of other local-bus targets, such as further slots or a coprocessor select. An active-low AND of all these lines is the same as a logical OR of the claims.

Top module: `lbus_claimer`

## Requirements
- R1: After reset, the claim output `ldev_n`, the ready output `rdy_n` and the merged claim `chip_claim_n` are all high, the data bus is not driven, and every register reads as zero.
- R2: A cycle starts on a rising edge where `ads_n` is low; `addr` and `wr` (1 = write, 0 = read) are latched at that edge. The cycle is claimed when `(addr & WIN_MASK) == WIN_BASE`. With the defaults, the claimed range is 0xC000_0000 through 0xDFFF_FFFF. An unclaimed cycle leaves `ldev_n` and `rdy_n` high and the bus undriven.
- R3: Call the strobe edge edge 0, and let W be the value of `wait_cfg` (0..7) at that edge. On a claimed cycle, `rdy_n` goes low after edge W+1 and returns high after edge W+2, so it is low for exactly one clock.
- R4: `ldev_n` goes low after edge 0 and stays low through the ready clock. It is released after the ready clock.
- R5: On a claimed read, the block drives `dbus` only during the ready clock, with the register selected by `addr[3:2]`.
- R6: On a claimed write, the block samples `dbus` at the edge that ends the ready clock. Byte i of the selected register is updated only where `be_n[i]` is 0.
- R7: `chip_claim_n` is low whenever `ldev_n` or any bit of `ext_claim_n` is low, and high otherwise.
- R8: A strobe that arrives while a claimed cycle is in progress is ignored. It starts no new cycle, adds no ready and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ads_n | input | 1 | Active-low cycle-start strobe from the host |
| wr | input | 1 | Cycle direction, 1 = write |
| addr | input | 32 | Cycle address |
| be_n | input | 4 | Active-low byte enables |
| wait_cfg | input | 3 | Wait clocks inserted before ready |
| dbus | inout | 32 | Shared data bus |
| ext_claim_n | input | 3 | Active-low claims from other local-bus targets |
| ldev_n | output | 1 | Active-low claim of the current cycle |
| rdy_n | output | 1 | Active-low cycle-terminating ready |
| chip_claim_n | output | 1 | Merged active-low claim to the chipset |

## Verification
The assertions assume that the host behaves like a real local-bus master. It opens a cycle only with a single-clock strobe, and it never issues a strobe on the edge where it samples ready. Every bench cycle follows that pattern. The one exception is the R8 scenario, which deliberately injects one extra strobe in the middle of a wait sequence and never on the ready edge. The bench drives `dbus` only for writes and for unclaimed reads, where it stands in for the chipset. This avoids any contention at the moment the block drives read data.

// File: rtl/lbus_claimer.sv
module lbus_claimer #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NREG = 4,
  parameter int NEXT = 3,
  parameter int WAIT_W = 3,
  parameter logic [AW-1:0] WIN_BASE = 32'hC000_0000,
  parameter logic [AW-1:0] WIN_MASK = 32'hE000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW/8-1:0]   be_n,
  input  logic [WAIT_W-1:0] wait_cfg,
  inout  wire  [DW-1:0]     dbus,
  input  logic [NEXT-1:0]   ext_claim_n,
  output logic              ldev_n,
  output logic              rdy_n,
  output logic              chip_claim_n
);
  localparam int NB  = DW / 8;
  localparam int LSB = $clog2(NB);
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_DONE} st_t;

  st_t               st;
  logic [WAIT_W-1:0] cnt;
  logic              is_wr;
  logic [IW-1:0]     idx;
  logic [DW-1:0]     rf [NREG];

  wire hit   = (addr & WIN_MASK) == WIN_BASE;
  wire start = !ads_n && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
      idx   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_HOLD;
          cnt   <= wait_cfg;
          is_wr <= wr;
          idx   <= addr[LSB +: IW];
        end
        S_HOLD: if (cnt == '0) st <= S_DONE;
                else           cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
    end else if (st == S_DONE && is_wr) begin
      for (int b = 0; b < NB; b++)
        if (!be_n[b]) rf[idx][8*b +: 8] <= dbus[8*b +: 8];
    end
  end

  assign ldev_n       = (st == S_IDLE);
  assign rdy_n        = (st != S_DONE);
  assign dbus         = (st == S_DONE && !is_wr) ? rf[idx] : 'z;
  assign chip_claim_n = &{ext_claim_n, ldev_n};
endmodule

// File: rtl/lbus_claimer_chk.sv
module lbus_claimer_chk (
  input logic clk,
  input logic rst_n,
  input logic ads_n,
  input logic ldev_n,
  input logic rdy_n,
  input logic chip_claim_n
);
  p_claim_after_ads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ldev_n) |-> $past(!ads_n));
  p_rdy_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |=> rdy_n);
  p_rdy_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> !ldev_n);
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |=> ldev_n);
  p_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ldev_n |-> !chip_claim_n);
endmodule

bind lbus_claimer lbus_claimer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ads_n(ads_n),
  .ldev_n(ldev_n), .rdy_n(rdy_n), .chip_claim_n(chip_claim_n)
);

// File: tb/sim_lbus_claimer.sv
`timescale 1ns/1ps
module sim_lbus_claimer;
  logic        clk = 0, rst_n = 0, ads_n = 1, wr = 0;
  logic [31:0] addr = 0;
  logic [3:0]  be_n = 4'hF;
  logic [2:0]  wait_cfg = 0;
  logic [2:0]  ext_claim_n = 3'b111;
  logic        tb_oe = 0;
  logic [31:0] tb_d = 0;
  wire  [31:0] dbus;
  logic        ldev_n, rdy_n, chip_claim_n;
  int n_chk = 0, n_fail = 0;

  assign dbus = tb_oe ? tb_d : 'z;
  always #2.5 clk = ~clk;

  lbus_claimer u0 (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .wr(wr), .addr(addr), .be_n(be_n),
    .wait_cfg(wait_cfg), .dbus(dbus), .ext_claim_n(ext_claim_n),
    .ldev_n(ldev_n), .rdy_n(rdy_n), .chip_claim_n(chip_claim_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One host cycle, starting and ending at a falling edge.
  task automatic cycle(input bit w, input logic [31:0] a, input logic [3:0] ben,
                       input logic [2:0] ws, input logic [31:0] wdata,
                       input bit claim, input logic [31:0] exp_rd, input int inject = -1);
    int n;
    bit held;
    addr = a; wr = w; be_n = ben; wait_cfg = ws; ads_n = 0;
    tb_oe = w || !claim;
    tb_d  = w ? wdata : 32'h5A5A_A5A5;
    @(posedge clk); @(negedge clk);
    ads_n = 1;
    if (!claim) begin
      held = 1;
      for (int k = 0; k < 10; k++) begin
        if (!ldev_n || !rdy_n || dbus !== tb_d) held = 0;
        @(posedge clk); @(negedge clk);
      end
      chk(held, "R2 unclaimed cycle stays quiet", {31'b0, held}, 32'd1);
      tb_oe = 0;
      return;
    end
    chk(ldev_n == 0, "R2/R4 claim after strobe", {31'b0, ldev_n}, 32'd0);
    n = 0; held = 1;
    while (rdy_n && n < 12) begin
      if (n == inject) begin ads_n = 0; wr = 1; addr = 32'hC000_000C; end
      @(posedge clk); @(negedge clk);
      ads_n = 1;
      n++;
      if (ldev_n) held = 0;
    end
    chk(n == int'(ws) + 1, "R3 ready position", n, int'(ws) + 1);
    chk(held, "R4 claim held to ready", {31'b0, held}, 32'd1);
    chk(chip_claim_n == 0, "R7 merged claim during cycle", {31'b0, chip_claim_n}, 32'd0);
    if (!w) chk(dbus === exp_rd, "R5 read data", dbus, exp_rd);
    @(posedge clk); @(negedge clk);
    tb_oe = 0;
    chk(rdy_n == 1, "R3 ready one clock", {31'b0, rdy_n}, 32'd1);
    chk(ldev_n == 1, "R4 claim released", {31'b0, ldev_n}, 32'd1);
    held = 1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      if (!rdy_n || !ldev_n) held = 0;
    end
    chk(held, "R8 no extra ready or claim", {31'b0, held}, 32'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ldev_n == 1 && rdy_n == 1 && chip_claim_n == 1, "R1 outputs idle in reset",
        {29'b0, ldev_n, rdy_n, chip_claim_n}, 32'h7);
    rst_n = 1;
    @(negedge clk);
    tb_oe = 1; tb_d = 32'h0F0F_1234;
    #0.1 chk(dbus === tb_d, "R1 bus released", dbus, tb_d);
    tb_oe = 0;
    cycle(0, 32'hC000_0008, 4'h0, 3'd0, 0, 1, 32'h0);
  endtask

  task automatic t_write_read;
    cycle(1, 32'hC000_0004, 4'h0, 3'd0, 32'h1234_5678, 1, 0);
    cycle(0, 32'hC000_0004, 4'h0, 3'd0, 0, 1, 32'h1234_5678);
    cycle(1, 32'hC000_0000, 4'h0, 3'd3, 32'hCAFE_F00D, 1, 0);
    cycle(0, 32'hC000_0000, 4'h0, 3'd7, 0, 1, 32'hCAFE_F00D);
  endtask

  task automatic t_bytes;
    cycle(1, 32'hC000_0008, 4'h0, 3'd1, 32'hFFFF_FFFF, 1, 0);
    cycle(1, 32'hC000_0008, 4'b1010, 3'd2, 32'h1122_3344, 1, 0);
    cycle(0, 32'hC000_0008, 4'h0, 3'd0, 0, 1, 32'hFF22_FF44); // R6
  endtask

  task automatic t_window;
    cycle(0, 32'hBFFF_FFFC, 4'h0, 3'd0, 0, 0, 0);
    cycle(0, 32'hE000_0000, 4'h0, 3'd0, 0, 0, 0);
    cycle(1, 32'hDFFF_FFFC, 4'h0, 3'd0, 32'h0BAD_BEEF, 1, 0);
    cycle(0, 32'hC000_000C, 4'h0, 3'd0, 0, 1, 32'h0BAD_BEEF); // R2 top edge aliases reg 3
  endtask

  task automatic t_merge;
    for (int s = 0; s < 3; s++) begin
      ext_claim_n = ~(3'b1 << s);
      #0.1 chk(chip_claim_n == 0, "R7 external claim merged", {31'b0, chip_claim_n}, 32'd0);
    end
    ext_claim_n = 3'b111;
    #0.1 chk(chip_claim_n == 1, "R7 no claim", {31'b0, chip_claim_n}, 32'd1);
    @(negedge clk);
  endtask

  task automatic t_ignore;
    cycle(0, 32'hC000_0004, 4'h0, 3'd5, 0, 1, 32'h1234_5678, 2);
    cycle(0, 32'hC000_000C, 4'h0, 3'd0, 0, 1, 32'h0BAD_BEEF); // R8 reg 3 untouched
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_write_read;
    t_bytes;
    t_window;
    t_merge;
    t_ignore;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule